// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This unit sits in the memory stage of a 32-bit integer pipeline whose instruction fetch and data traffic share one bus. For each request it receives an operation code (byte, half-word or word, signed or unsigned load, or store), an effective address and the store operand. In the same cycle it presents a word-aligned bus address, a four-lane byte-enable, the store operand copied into the enabled lanes, a write strobe and a flag for accesses that break natural alignment. A misaligned request never reaches the bus.

For an issued load, the unit registers the lane enable and the extension mode. The read word returns in the next cycle, and the unit uses the registered enable to pick the addressed byte or half-word, then sign- or zero-extends it into a 32-bit value for register writeback. A new request may be issued in the same cycle in which the previous load's data comes back. Trap handling, caching and bus arbitration are left to neighbouring blocks.

Top module: `lsu_lane_align`

## Requirements
- R1: When `bus_valid` is high, `bus_addr` equals `req_addr` with bits 1:0 forced to zero.
- R2: An aligned byte access (size field 2'b00) enables exactly lane `req_addr[1:0]`. Lane n carries data bits 8n+7:8n.
- R3: A half-word access (size field 2'b01) with `req_addr[0]`=0 enables lanes 1:0 (mask 4'b0011) when `req_addr[1]`=0, and lanes 3:2 (mask 4'b1100) when `req_addr[1]`=1.
- R4: A word access (size field 2'b10) with `req_addr[1:0]`=0 enables all four lanes (mask 4'b1111).
- R5: A half-word access with `req_addr[0]`=1, or a word access with `req_addr[1:0]`≠0, raises `misalign` and drives `bus_valid`=0, `bus_we`=0 and `bus_be`=4'b0000.
- R6: A store drives `bus_we`=1 and copies its operand into the lanes: a byte goes to all four lanes, a half-word to both halves, and a word is passed unchanged. A load drives `bus_we`=0 and `bus_wdata`=0.
- R7: The load issued in cycle N is answered in cycle N+1. In that cycle `ld_valid` equals `rsp_valid`, and `ld_data` is taken from `bus_rdata` using the lane enable registered at issue, even if a different request is issued in cycle N+1. In any cycle that does not follow an issued load, `ld_valid` stays 0.
- R8: Signed byte and half-word loads sign-extend the selected bits to 32 bits. Unsigned loads zero-extend them. Word loads return the read word unchanged.
- R9: `req_op` is coded {store, unsigned, size[1:0]}. The legal codes are LB=0000, LH=0001, LW=0010, LBU=0100, LHU=0101, SB=1000, SH=1001 and SW=1010. Any other code, or `req_valid`=0, produces no access (`bus_valid`=0, `bus_be`=0, `bus_we`=0, `bus_wdata`=0) and `misalign`=0.
- R10: After reset, no load is pending, so `ld_valid` is 0 even when `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code {store, unsigned, size} |
| req_addr | input | ADDR_W | Effective byte address |
| req_wdata | input | 32 | Store operand, right-aligned |
| bus_valid | output | 1 | Bus access issued |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_be | output | 4 | Byte-lane enable |
| bus_wdata | output | 32 | Lane-placed write data |
| misalign | output | 1 | Request breaks natural alignment |
| rsp_valid | input | 1 | Read word present on bus_rdata |
| bus_rdata | input | 32 | Read word from the bus |
| ld_valid | output | 1 | Writeback value valid |
| ld_data | output | 32 | Extracted and extended load value |

## Verification
Two functions can fall in the same cycle: the request path for a new operation and the extraction of the previous load's returned word. The bench runs all sixteen opcodes against all four address offsets back to back. Each step issues a new request and, in the same cycle, returns data for the step before, so every pair of consecutive steps overlaps. The load value is judged against the offset and size of the earlier request, computed by shifting in the bench. A mix-up with the lanes of the current request therefore shows up whenever the two offsets differ.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

   typedef enum logic [3:0] {
      OP_LB  = 4'b0000,
      OP_LH  = 4'b0001,
      OP_LW  = 4'b0010,
      OP_LBU = 4'b0100,
      OP_LHU = 4'b0101,
      OP_SB  = 4'b1000,
      OP_SH  = 4'b1001,
      OP_SW  = 4'b1010
   } mem_op_e;

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;

   typedef struct packed {
      logic       legal;
      logic       store;
      logic       uns;
      logic [1:0] size;
   } op_dec_t;

   function automatic op_dec_t decode_op(logic [3:0] code);
      op_dec_t d;
      d.store = code[3];
      d.uns   = code[2];
      d.size  = code[1:0];
      d.legal = (code[1:0] != 2'b11)
              && !(code[3] && code[2])
              && !(code[1:0] == SZ_WORD && code[2]);
      return d;
   endfunction

endpackage

// File: rtl/lsu_lane_mask.sv
module lsu_lane_mask #(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [1:0]       size,
   input  logic [OFF_W-1:0] off,
   output logic [LANES-1:0] mask,
   output logic             misal
);
   import lsu_lane_pkg::*;

   logic [LANES-1:0] byte_m;
   logic [LANES-1:0] half_m;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign byte_m[i] = (int'(off) == i);
      assign half_m[i] = (i / 2 == int'(off[OFF_W-1]));
   end

   always_comb begin
      unique case (size)
         SZ_BYTE: begin mask = byte_m;         misal = 1'b0;    end
         SZ_HALF: begin mask = half_m;         misal = off[0];  end
         SZ_WORD: begin mask = '1;             misal = |off;    end
         default: begin mask = '0;             misal = 1'b0;    end
      endcase
   end
endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack #(
   parameter int LANES = 4
) (
   input  logic [1:0]         size,
   input  logic [8*LANES-1:0] wdata,
   output logic [8*LANES-1:0] lanes
);
   import lsu_lane_pkg::*;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
         unique case (size)
            SZ_BYTE: lanes[8*i +: 8] = wdata[7:0];
            SZ_HALF: lanes[8*i +: 8] = wdata[8*(i%2) +: 8];
            default: lanes[8*i +: 8] = wdata[8*i +: 8];
         endcase
      end
   end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
   parameter int LANES = 4,
   localparam int DW = 8 * LANES
) (
   input  logic [LANES-1:0] mask,
   input  logic [1:0]       size,
   input  logic             uns,
   input  logic [DW-1:0]    rdata,
   output logic [DW-1:0]    value
);
   import lsu_lane_pkg::*;

   logic [LANES-1:0][7:0] gated;
   logic [7:0]            sel_b;
   logic [15:0]           sel_h;

   for (genvar i = 0; i < LANES; i++) begin : g_gate
      assign gated[i] = rdata[8*i +: 8] & {8{mask[i]}};
   end

   always_comb begin
      sel_b = '0;
      for (int i = 0; i < LANES; i++) sel_b = sel_b | gated[i];
      sel_h = mask[LANES-1] ? rdata[DW-1 -: 16] : rdata[15:0];
      unique case (size)
         SZ_BYTE: value = {{(DW-8){sel_b[7] & ~uns}}, sel_b};
         SZ_HALF: value = {{(DW-16){sel_h[15] & ~uns}}, sel_h};
         default: value = rdata;
      endcase
   end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter bit REG_LOAD_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [3:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              bus_valid,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [3:0]        bus_be,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              misalign,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_data
);
   import lsu_lane_pkg::*;

   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("lsu_lane_align: DATA_W must be 32");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("lsu_lane_align: ADDR_W must be at least 3");
   end

   op_dec_t          dec;
   logic [LANES-1:0] raw_mask;
   logic             raw_misal;
   logic [DATA_W-1:0] packed_w;
   logic             live;

   assign dec  = decode_op(req_op);
   assign live = req_valid && dec.legal;

   lsu_lane_mask #(.LANES(LANES)) mask_i (
      .size  (dec.size),
      .off   (req_addr[OFF_W-1:0]),
      .mask  (raw_mask),
      .misal (raw_misal)
   );

   lsu_store_pack #(.LANES(LANES)) pack_i (
      .size  (dec.size),
      .wdata (req_wdata),
      .lanes (packed_w)
   );

   assign misalign  = live && raw_misal;
   assign bus_valid = live && !raw_misal;
   assign bus_we    = bus_valid && dec.store;
   assign bus_be    = bus_valid ? raw_mask : '0;
   assign bus_wdata = bus_we ? packed_w : '0;
   assign bus_addr  = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   logic             pend_q;
   logic [LANES-1:0] pend_mask_q;
   logic [1:0]       pend_size_q;
   logic             pend_uns_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_mask_q <= '0;
         pend_size_q <= SZ_BYTE;
         pend_uns_q  <= 1'b0;
      end else begin
         pend_q <= bus_valid && !dec.store;
         if (bus_valid && !dec.store) begin
            pend_mask_q <= raw_mask;
            pend_size_q <= dec.size;
            pend_uns_q  <= dec.uns;
         end
      end
   end

   logic [DATA_W-1:0] ext_val;

   lsu_load_extract #(.LANES(LANES)) ext_i (
      .mask  (pend_mask_q),
      .size  (pend_size_q),
      .uns   (pend_uns_q),
      .rdata (bus_rdata),
      .value (ext_val)
   );

   if (REG_LOAD_OUT) begin : g_reg_out
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else begin
            v_q <= pend_q && rsp_valid;
            d_q <= ext_val;
         end
      end
      assign ld_valid = v_q;
      assign ld_data  = d_q;
   end else begin : g_comb_out
      assign ld_valid = pend_q && rsp_valid;
      assign ld_data  = ext_val;
   end
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_be,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              misalign,
   input logic              ld_valid
);
   assert_word_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> bus_addr[1:0] == 2'b00);

   assert_be_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> ($countones(bus_be) == 1 || bus_be == 4'b0011
                     || bus_be == 4'b1100 || bus_be == 4'b1111));

   assert_misalign_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!bus_valid && bus_be == 4'b0000 && !bus_we));

   assert_read_no_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we) |-> bus_wdata == '0);

   assert_ld_follows_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(bus_valid && !bus_we));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> (bus_be == 4'b0000 && !bus_we && bus_wdata == '0));
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_wdata (bus_wdata),
   .misalign  (misalign),
   .ld_valid  (ld_valid)
);

// File: tb/lsu_lane_align_tb_top.sv
module lsu_lane_align_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [3:0]  req_op;
   logic [31:0] req_addr;
   logic [31:0] req_wdata;
   logic        bus_valid, bus_we, misalign, ld_valid;
   logic [31:0] bus_addr, bus_wdata, ld_data;
   logic [3:0]  bus_be;
   logic        rsp_valid;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   lsu_lane_align dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .bus_valid(bus_valid),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .misalign(misalign), .rsp_valid(rsp_valid),
      .bus_rdata(bus_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit is_legal(logic [3:0] c);
      return c inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b0101,
                       4'b1000, 4'b1001, 4'b1010};
   endfunction

   function automatic logic [31:0] exp_load(logic [3:0] c, logic [1:0] off,
                                            logic [31:0] rd);
      logic [31:0] s;
      if (c[1:0] == 2'b00) begin
         s = (rd >> (8 * off)) & 32'hFF;
         if (!c[2] && s[7]) s = s | 32'hFFFF_FF00;
      end else if (c[1:0] == 2'b01) begin
         s = (rd >> (16 * off[1])) & 32'hFFFF;
         if (!c[2] && s[15]) s = s | 32'hFFFF_0000;
      end else begin
         s = rd;
      end
      return s;
   endfunction

   bit          prev_load;
   logic [3:0]  prev_op;
   logic [1:0]  prev_off;

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
      req_wdata = '0; rsp_valid = 1'b0; bus_rdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1; rsp_valid = 1'b1; bus_rdata = 32'hDEAD_BEEF;
      #5;
      chk("R10 ld_valid after reset", {31'b0, ld_valid}, 32'd0);
      chk("R9 idle bus_valid", {31'b0, bus_valid}, 32'd0);
      chk("R9 idle bus_be", {28'b0, bus_be}, 32'd0);
      chk("R9 idle misalign", {31'b0, misalign}, 32'd0);

      prev_load = 1'b0; prev_op = '0; prev_off = '0;

      // Back-to-back sweep: every opcode x every offset; each step also
      // returns the read word for the previous step (R7 overlap).
      for (int k = 0; k < 64; k++) begin
         logic [3:0]  c;
         logic [1:0]  off;
         logic [31:0] a, w, rd, m, pw;
         bit          lg, mis, iss;
         c   = 4'(k >> 2);
         off = 2'(k);
         a   = (32'h1357_9BD0 + 32'(k) * 32'h0004_0010) | 32'(off);
         w   = 32'hA5C3_1E87 ^ (32'(k) * 32'h0101_0101);
         rd  = 32'h9E37_79B9 * 32'(k + 1);
         lg  = is_legal(c);
         mis = lg && ((c[1:0] == 2'b01 && off[0]) || (c[1:0] == 2'b10 && off != 0));
         iss = lg && !mis;
         if (c[1:0] == 2'b00)      m = 32'd1 << off;
         else if (c[1:0] == 2'b01) m = off[1] ? 32'hC : 32'h3;
         else                      m = 32'hF;
         if (c[1:0] == 2'b00)      pw = {4{w[7:0]}};
         else if (c[1:0] == 2'b01) pw = {2{w[15:0]}};
         else                      pw = w;

         @(negedge clk);
         req_valid = 1'b1; req_op = c; req_addr = a; req_wdata = w;
         rsp_valid = 1'b1; bus_rdata = rd;
         #5;
         chk("R9 bus_valid", {31'b0, bus_valid}, {31'b0, iss});
         chk("R5 misalign", {31'b0, misalign}, {31'b0, mis});
         chk("R6 bus_we", {31'b0, bus_we}, {31'b0, iss && c[3]});
         if (iss) begin
            chk("R1 bus_addr", bus_addr, a & 32'hFFFF_FFFC);
            if (c[1:0] == 2'b00)      chk("R2 byte mask", {28'b0, bus_be}, m);
            else if (c[1:0] == 2'b01) chk("R3 half mask", {28'b0, bus_be}, m);
            else                      chk("R4 word mask", {28'b0, bus_be}, m);
            chk("R6 bus_wdata", bus_wdata, c[3] ? pw : 32'd0);
         end else begin
            chk("R5 blocked mask", {28'b0, bus_be}, 32'd0);
            chk("R9 no write data", bus_wdata, 32'd0);
         end
         chk("R7 ld_valid", {31'b0, ld_valid}, {31'b0, prev_load});
         if (prev_load)
            chk("R8 ld_data", ld_data, exp_load(prev_op, prev_off, rd));
         prev_load = iss && !c[3];
         prev_op   = c;
         prev_off  = off;
      end

      // req_valid low with a legal opcode: no access (R9)
      @(negedge clk);
      req_valid = 1'b0; req_op = 4'b0010; req_addr = 32'h0000_0100;
      rsp_valid = 1'b0;
      #5;
      chk("R9 req_valid low bus_valid", {31'b0, bus_valid}, 32'd0);
      chk("R9 req_valid low misalign", {31'b0, misalign}, 32'd0);

      // signed byte load, then no response: ld_valid must stay low (R7)
      @(negedge clk);
      req_valid = 1'b1; req_op = 4'b0000; req_addr = 32'h0000_0203;
      #5;
      chk("R2 byte lane 3", {28'b0, bus_be}, 32'h8);
      @(negedge clk);
      req_valid = 1'b0; rsp_valid = 1'b0; bus_rdata = 32'h8000_0000;
      #5;
      chk("R7 no rsp ld_valid", {31'b0, ld_valid}, 32'd0);
      chk("R8 lane 3 sign extend", ld_data, 32'hFFFF_FF80);

      // unsigned half load high half: zero extension (R8)
      @(negedge clk);
      req_valid = 1'b1; req_op = 4'b0101; req_addr = 32'h0000_0402;
      #5;
      @(negedge clk);
      req_valid = 1'b0; rsp_valid = 1'b1; bus_rdata = 32'hF00D_1234;
      #5;
      chk("R7 rsp ld_valid", {31'b0, ld_valid}, 32'd1);
      chk("R8 half zero extend", ld_data, 32'h0000_F00D);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule